// File: doc/BRIEF.md
# Reorder Buffer with Speculative Squash

This block keeps issued instructions in program order from the moment they are dispatched until they leave the machine. Each dispatch claims the entry at the tail of a circular store of eight slots. It records the destination register, whether the instruction is a branch, and the address at which fetch must restart if that branch turns out to be mispredicted. The slot number is handed back as a tag. Execution units later present a tag and a value on a result bus. That value is held in the slot, and the slot is marked finished in the same cycle.

Architectural state changes only at the head. Only the oldest slot may leave, only once it is finished, and only one slot leaves per cycle. A leaving non-branch slot drives the register-file write port. A slow instruction at the head therefore holds back every younger finished instruction, and the store fills behind it.

Branches are resolved through a separate port. A resolved branch counts as finished. If the prediction was wrong, every slot younger than the branch is dropped in that cycle, the tail moves to the slot just after the branch, and a redirect carrying the stored restart address is raised. A dispatch offered in that same cycle is refused.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: dispReady is 1, robFull is 0, retireValid is 0, redirectValid is 0 and dispTag is 0.
- R2: Each accepted dispatch is given the current tail slot as its tag on dispTag, and tags advance by one modulo 8.
- R3: When 8 slots are in use, robFull is 1 and dispReady is 0, and a dispatch offered then is ignored, so it never retires.
- R4: Only the oldest slot retires, and only once it is finished; younger finished slots wait behind an unfinished oldest slot.
- R5: At most one slot retires per cycle, so a run of finished slots drains one per cycle in program order.
- R6: The register file is written (rfWe=1, rfAddr = destination, rfData = stored value) only in the cycle a non-branch slot retires, never when its result appears on the result bus.
- R7: A result-bus write with tag T stores the value in slot T and marks it finished at that clock edge, so slot T can retire from the next cycle on.
- R8: A branch resolved as correctly predicted becomes finished, raises no redirect, and later retires with rfWe=0.
- R9: A branch resolved as mispredicted raises redirectValid in that cycle, with redirectPc equal to the restart address given at its dispatch, and all younger slots are discarded without ever writing the register file.
- R10: After a squash, the next dispatch receives the tag of the slot just after the branch.
- R11: In a squash cycle dispReady is 0 and a dispatch offered then is dropped.
- R12: Dispatch, result write and retirement may all happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | Dispatch request |
| dispDest | input | 5 | Destination register of the dispatched instruction |
| dispIsBranch | input | 1 | Dispatched instruction is a branch |
| dispAltPc | input | 32 | Restart address used if the branch is mispredicted |
| dispReady | output | 1 | Dispatch is accepted this cycle |
| dispTag | output | 3 | Tag given to a dispatch this cycle |
| robFull | output | 1 | All slots are in use |
| wbValid | input | 1 | Result-bus write |
| wbTag | input | 3 | Slot addressed by the result |
| wbData | input | 32 | Result value |
| brValid | input | 1 | Branch resolution |
| brTag | input | 3 | Slot of the resolved branch |
| brMispredict | input | 1 | Resolved branch was mispredicted |
| redirectValid | output | 1 | Fetch must restart |
| redirectPc | output | 32 | Restart address |
| retireValid | output | 1 | Oldest slot leaves this cycle |
| rfWe | output | 1 | Register-file write enable |
| rfAddr | output | 5 | Register-file write address |
| rfData | output | 32 | Register-file write data |

## Verification
The hardest state to reach is a mispredicted branch that sits behind an unfinished oldest instruction while younger slots on the wrong path have already finished. The stimulus holds back the oldest result and completes one wrong-path slot early. It then drains the slots ahead of the branch, resolves the branch as mispredicted, and offers a dispatch in that same cycle. The wrong-path slot's tag is then reused and given a different value, so any leak of the discarded result would show up on rfData.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef struct packed {
    logic allocEn;
    logic wbEn;
    logic brEn;
    logic retireEn;
    logic flushEn;
  } rob_strobe_t;
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dispValid,
  input  logic             wbValid,
  input  logic             brValid,
  input  logic             brMispredict,
  input  logic [TAG_W-1:0] brTag,
  input  logic             headDone,
  output rob_strobe_t      strb,
  output logic [TAG_W-1:0] headIdx,
  output logic [TAG_W-1:0] tailIdx,
  output logic             dispReady,
  output logic             robFull,
  output logic             retireValid,
  output logic             redirectValid
);
  localparam logic [TAG_W-1:0] ONE      = TAG_W'(1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [TAG_W-1:0] headQ, tailQ;
  logic [CNT_W-1:0] countQ, countN;
  logic [TAG_W-1:0] brDist;
  logic flush, alloc, retire;

  assign flush     = brValid && brMispredict;
  assign robFull   = (countQ == FULL_CNT);
  assign dispReady = !robFull && !flush;
  assign alloc     = dispValid && dispReady;
  assign retire    = (countQ != '0) && headDone;
  assign brDist    = brTag - headQ;

  always_comb begin
    if (flush)
      countN = CNT_W'(brDist) + CNT_W'(1) - CNT_W'(retire);
    else
      countN = countQ + CNT_W'(alloc) - CNT_W'(retire);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ  <= '0;
      tailQ  <= '0;
      countQ <= '0;
    end else begin
      headQ  <= retire ? headQ + ONE : headQ;
      tailQ  <= flush ? brTag + ONE : (alloc ? tailQ + ONE : tailQ);
      countQ <= countN;
    end
  end

  assign strb.allocEn  = alloc;
  assign strb.wbEn     = wbValid;
  assign strb.brEn     = brValid;
  assign strb.retireEn = retire;
  assign strb.flushEn  = flush;

  assign headIdx       = headQ;
  assign tailIdx       = tailQ;
  assign retireValid   = retire;
  assign redirectValid = flush;

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= FULL_CNT);

  a_r10_tail_after_squash: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> tailQ == $past(brTag) + ONE);

  a_r5_single_step: assert property (@(posedge clk) disable iff (!rstN)
    !flush |=> (countQ == $past(countQ)) || (countQ == $past(countQ) + CNT_W'(1))
               || (countQ + CNT_W'(1) == $past(countQ)));
endmodule

// File: rtl/rob_store.sv
module rob_store
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = $clog2(DEPTH),
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int PC_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  rob_strobe_t       strb,
  input  logic [TAG_W-1:0]  tailIdx,
  input  logic [TAG_W-1:0]  headIdx,
  input  logic [REG_W-1:0]  dispDest,
  input  logic              dispIsBranch,
  input  logic [PC_W-1:0]   dispAltPc,
  input  logic [TAG_W-1:0]  wbTag,
  input  logic [DATA_W-1:0] wbData,
  input  logic [TAG_W-1:0]  brTag,
  output logic              headDone,
  output logic              headIsBranch,
  output logic [REG_W-1:0]  headDest,
  output logic [DATA_W-1:0] headData,
  output logic [PC_W-1:0]   brAltPc
);
  logic [DEPTH-1:0]  doneVec;
  logic [DEPTH-1:0]  branchVec;
  logic [REG_W-1:0]  destArr [DEPTH];
  logic [DATA_W-1:0] dataArr [DEPTH];
  logic [PC_W-1:0]   pcArr   [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic              doneQ, branchQ;
    logic [REG_W-1:0]  destQ;
    logic [DATA_W-1:0] dataQ;
    logic [PC_W-1:0]   pcQ;
    logic hitAlloc, hitWb, hitBr;

    assign hitAlloc = strb.allocEn && (tailIdx == TAG_W'(g));
    assign hitWb    = strb.wbEn && (wbTag == TAG_W'(g));
    assign hitBr    = strb.brEn && (brTag == TAG_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        doneQ   <= 1'b0;
        branchQ <= 1'b0;
        destQ   <= '0;
        dataQ   <= '0;
        pcQ     <= '0;
      end else if (hitAlloc) begin
        doneQ   <= 1'b0;
        branchQ <= dispIsBranch;
        destQ   <= dispDest;
        pcQ     <= dispAltPc;
      end else if (hitWb) begin
        doneQ <= 1'b1;
        dataQ <= wbData;
      end else if (hitBr) begin
        doneQ <= 1'b1;
      end
    end

    assign doneVec[g]   = doneQ;
    assign branchVec[g] = branchQ;
    assign destArr[g]   = destQ;
    assign dataArr[g]   = dataQ;
    assign pcArr[g]     = pcQ;
  end

  assign headDone     = doneVec[headIdx];
  assign headIsBranch = branchVec[headIdx];
  assign headDest     = destArr[headIdx];
  assign headData     = dataArr[headIdx];
  assign brAltPc      = pcArr[brTag];

  a_r4_retire_finished: assert property (@(posedge clk) disable iff (!rstN)
    strb.retireEn |-> doneVec[headIdx]);

  a_r7_result_marks: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wbEn && !(strb.allocEn && tailIdx == wbTag)) |=> doneVec[$past(wbTag)]);

  a_r2_alloc_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.allocEn |=> !doneVec[$past(tailIdx)]);
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = $clog2(DEPTH),
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int PC_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dispValid,
  input  logic [REG_W-1:0]  dispDest,
  input  logic              dispIsBranch,
  input  logic [PC_W-1:0]   dispAltPc,
  output logic              dispReady,
  output logic [TAG_W-1:0]  dispTag,
  output logic              robFull,
  input  logic              wbValid,
  input  logic [TAG_W-1:0]  wbTag,
  input  logic [DATA_W-1:0] wbData,
  input  logic              brValid,
  input  logic [TAG_W-1:0]  brTag,
  input  logic              brMispredict,
  output logic              redirectValid,
  output logic [PC_W-1:0]   redirectPc,
  output logic              retireValid,
  output logic              rfWe,
  output logic [REG_W-1:0]  rfAddr,
  output logic [DATA_W-1:0] rfData
);
  rob_strobe_t      strb;
  logic [TAG_W-1:0] headIdx, tailIdx;
  logic             headDone, headIsBranch;

  rob_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .wbValid(wbValid),
    .brValid(brValid), .brMispredict(brMispredict), .brTag(brTag),
    .headDone(headDone), .strb(strb), .headIdx(headIdx), .tailIdx(tailIdx),
    .dispReady(dispReady), .robFull(robFull), .retireValid(retireValid),
    .redirectValid(redirectValid)
  );

  rob_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W), .REG_W(REG_W),
              .PC_W(PC_W)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .tailIdx(tailIdx), .headIdx(headIdx),
    .dispDest(dispDest), .dispIsBranch(dispIsBranch), .dispAltPc(dispAltPc),
    .wbTag(wbTag), .wbData(wbData), .brTag(brTag), .headDone(headDone),
    .headIsBranch(headIsBranch), .headDest(rfAddr), .headData(rfData),
    .brAltPc(redirectPc)
  );

  assign dispTag = tailIdx;
  assign rfWe    = retireValid && !headIsBranch;

  a_r6_write_at_retire: assert property (@(posedge clk) disable iff (!rstN)
    rfWe |-> headDone);
endmodule

// File: tb/tb_rob_core.sv
`timescale 1ns/1ps
module tb_rob_core;
  logic        clk = 1'b0;
  logic        rstN;
  logic        dispValid, dispIsBranch, dispReady, robFull;
  logic [4:0]  dispDest, rfAddr;
  logic [31:0] dispAltPc, wbData, redirectPc, rfData;
  logic [2:0]  dispTag, wbTag, brTag;
  logic        wbValid, brValid, brMispredict, redirectValid, retireValid, rfWe;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rob_core dut (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispDest(dispDest),
    .dispIsBranch(dispIsBranch), .dispAltPc(dispAltPc), .dispReady(dispReady),
    .dispTag(dispTag), .robFull(robFull), .wbValid(wbValid), .wbTag(wbTag),
    .wbData(wbData), .brValid(brValid), .brTag(brTag), .brMispredict(brMispredict),
    .redirectValid(redirectValid), .redirectPc(redirectPc), .retireValid(retireValid),
    .rfWe(rfWe), .rfAddr(rfAddr), .rfData(rfData)
  );

  typedef struct packed {
    logic dv; logic [4:0] dd; logic db; logic [15:0] dpc;
    logic wv; logic [2:0] wt; logic [15:0] wd;
    logic bv; logic [2:0] bt; logic bm;
    logic [2:0] eTag; logic eRdy; logic eRet; logic eWe; logic [4:0] eAddr; logic [15:0] eData;
    logic eRed; logic [15:0] ePc;
  } vec_t;

  localparam int NROW = 18;
  localparam vec_t TBL [NROW] = '{
    '{1,1,0,0,      0,0,0,      0,0,0, 0,1,0,0,0,0,      0,0},
    '{1,2,0,0,      0,0,0,      0,0,0, 1,1,0,0,0,0,      0,0},
    '{1,3,0,0,      1,1,'h22,   0,0,0, 2,1,0,0,0,0,      0,0},
    '{1,0,1,'h100,  0,0,0,      0,0,0, 3,1,0,0,0,0,      0,0},
    '{1,4,0,0,      0,0,0,      0,0,0, 4,1,0,0,0,0,      0,0},
    '{1,5,0,0,      1,4,'h44,   0,0,0, 5,1,0,0,0,0,      0,0},
    '{0,0,0,0,      1,0,'h11,   0,0,0, 6,1,0,0,0,0,      0,0},
    '{0,0,0,0,      1,2,'h33,   0,0,0, 6,1,1,1,1,'h11,   0,0},
    '{0,0,0,0,      0,0,0,      0,0,0, 6,1,1,1,2,'h22,   0,0},
    '{0,0,0,0,      0,0,0,      0,0,0, 6,1,1,1,3,'h33,   0,0},
    '{1,7,0,0,      0,0,0,      1,3,1, 6,0,0,0,0,0,      1,'h100},
    '{1,6,0,0,      0,0,0,      0,0,0, 4,1,1,0,0,0,      0,0},
    '{0,0,0,0,      1,4,'h66,   0,0,0, 5,1,0,0,0,0,      0,0},
    '{0,0,0,0,      0,0,0,      0,0,0, 5,1,1,1,6,'h66,   0,0},
    '{1,0,1,'h200,  0,0,0,      0,0,0, 5,1,0,0,0,0,      0,0},
    '{0,0,0,0,      0,0,0,      1,5,0, 6,1,0,0,0,0,      0,0},
    '{0,0,0,0,      0,0,0,      0,0,0, 6,1,1,0,0,0,      0,0},
    '{0,0,0,0,      0,0,0,      0,0,0, 6,1,0,0,0,0,      0,0}
  };
  localparam string ROWREQ [NROW] = '{
    "R2", "R2", "R7", "R2", "R2", "R4", "R4", "R6", "R5", "R5",
    "R9 R11", "R10", "R9", "R9", "R8", "R8", "R8", "R8"
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    dispValid = 0; dispDest = 0; dispIsBranch = 0; dispAltPc = 0;
    wbValid = 0; wbTag = 0; wbData = 0;
    brValid = 0; brTag = 0; brMispredict = 0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0; idle();
    repeat (2) @(negedge clk);
    rstN = 1;
    #1;
    chk("R1 ready", {31'b0, dispReady}, 1);
    chk("R1 full", {31'b0, robFull}, 0);
    chk("R1 retire", {31'b0, retireValid}, 0);
    chk("R1 redirect", {31'b0, redirectValid}, 0);
    chk("R1 tag", {29'b0, dispTag}, 0);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 0; idle();
    doReset();

    // Table: in-order retire, blocking head, squash, correct branch
    for (int r = 0; r < NROW; r++) begin
      @(negedge clk);
      dispValid = TBL[r].dv; dispDest = TBL[r].dd; dispIsBranch = TBL[r].db;
      dispAltPc = {16'b0, TBL[r].dpc};
      wbValid = TBL[r].wv; wbTag = TBL[r].wt; wbData = {16'b0, TBL[r].wd};
      brValid = TBL[r].bv; brTag = TBL[r].bt; brMispredict = TBL[r].bm;
      #1;
      chk(ROWREQ[r], {29'b0, dispTag}, {29'b0, TBL[r].eTag});
      chk(ROWREQ[r], {31'b0, dispReady}, {31'b0, TBL[r].eRdy});
      chk(ROWREQ[r], {31'b0, retireValid}, {31'b0, TBL[r].eRet});
      chk(ROWREQ[r], {31'b0, rfWe}, {31'b0, TBL[r].eWe});
      if (TBL[r].eWe) begin
        chk(ROWREQ[r], {27'b0, rfAddr}, {27'b0, TBL[r].eAddr});
        chk(ROWREQ[r], rfData, {16'b0, TBL[r].eData});
      end
      chk(ROWREQ[r], {31'b0, redirectValid}, {31'b0, TBL[r].eRed});
      if (TBL[r].eRed) chk(ROWREQ[r], redirectPc, {16'b0, TBL[r].ePc});
    end

    // R1: reset again with state present
    doReset();

    // R3: fill all eight slots
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); idle();
      dispValid = 1; dispDest = 5'(i + 1);
      #1;
      chk("R2 fill tag", {29'b0, dispTag}, i);
      chk("R3 ready while filling", {31'b0, dispReady}, 1);
    end
    @(negedge clk); idle();
    dispValid = 1; dispDest = 31;
    #1;
    chk("R3 full flag", {31'b0, robFull}, 1);
    chk("R3 ready when full", {31'b0, dispReady}, 0);

    // R4: younger slots finish first, head still blocks
    for (int k = 7; k >= 1; k--) begin
      @(negedge clk); idle();
      wbValid = 1; wbTag = 3'(k); wbData = 32'hA0 + k;
      #1;
      chk("R4 blocked by head", {31'b0, retireValid}, 0);
    end
    @(negedge clk); idle();
    wbValid = 1; wbTag = 0; wbData = 32'hA0;
    #1;
    chk("R6 no write on result bus", {31'b0, rfWe}, 0);

    // R5: drain one per cycle; R12: dispatch alongside retire and result
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); idle();
      if (i == 1) begin
        dispValid = 1; dispDest = 20;
        wbValid = 1; wbTag = 3; wbData = 32'hA3;
      end
      #1;
      chk("R5 retire", {31'b0, retireValid}, 1);
      chk("R5 order addr", {27'b0, rfAddr}, i + 1);
      chk("R6 data", rfData, 32'hA0 + i);
      if (i == 1) begin
        chk("R12 ready with retire", {31'b0, dispReady}, 1);
        chk("R12 tag wraps", {29'b0, dispTag}, 0);
      end
    end
    @(negedge clk); idle();
    #1;
    chk("R3 ignored dispatch absent", {31'b0, retireValid}, 0);
    @(negedge clk); idle();
    wbValid = 1; wbTag = 0; wbData = 32'h55;
    #1;
    chk("R7 not yet", {31'b0, retireValid}, 0);
    @(negedge clk); idle();
    #1;
    chk("R12 new slot retires", {27'b0, rfAddr}, 20);
    chk("R7 value stored", rfData, 32'h55);
    chk("R6 write", {31'b0, rfWe}, 1);
    @(negedge clk); idle();
    #1;
    chk("R3 empty after drain", {31'b0, retireValid}, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule